// File: doc/BRIEF.md
# External Interrupt Detector with Glitch Filter

This block watches four external request pins and turns activity on them into pending interrupt flags for a small CPU. Each input has its own two-bit trigger-form field. Inputs 0 and 1 can react to a rising edge, a falling edge, a high level or a low level. Inputs 2 and 3 can react to a rising edge, a falling edge or to both edges. Every raw pin passes through a two-flop synchroniser that runs on the instruction-cycle clock. Input 3 also passes through a sampled glitch filter whose sample rate is the instruction cycle divided by 1, 16 or 64.

The CPU reads the pending flags, a request line and the vector of the winning input. Input 0 has the highest priority. When it writes a clear strobe, that flag drops and the others stay as they are. The same edge detectors can also drive a single-cycle count pulse for a timer event input. The source is either input 2 or the filtered input 3.

Top module: `ext_irq_unit`

## Requirements
- R1: A change on pin_i[0..2] reaches pend_o on the third rising clock edge after the pin changes: two synchroniser stages, then the flag register.
- R2: Inputs 0 and 1 decode their mode field as 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R3: Inputs 2 and 3 decode their mode field as 00 rising edge, 01 falling edge, 10 or 11 both edges. They never sense levels.
- R4: In an edge mode a set flag stays set until its clr_i bit is pulsed. When an edge and a clear arrive in the same cycle, the flag is set.
- R5: In a level mode the flag equals the active condition of the input while en_i is high, and is low while en_i is low. A clear strobe has no lasting effect.
- R6: While en_i of an input is low, its edges do not set the flag. A flag that is already set stays set until it is cleared.
- R7: vec_o gives the vector of the lowest-numbered pending input: 03h, 0Bh, 13h or 1Bh for inputs 0 to 3. vec_o is 00h and irq_o is low when nothing is pending. Flags that lose the priority contest stay pending.
- R8: rate_i selects the input 3 sample rate: 00 every cycle, 01 every 16 cycles, 10 or 11 every 64 cycles. The filter output takes a new level only after two consecutive equal samples. At rate 00 a 1-cycle pulse is rejected and a 2-cycle pulse is accepted. At rate 01 a 10-cycle pulse is rejected and a 40-cycle pulse is accepted. At rate 11 a 40-cycle pulse is rejected, and at rate 10 a 140-cycle pulse is accepted.
- R9: tmr_evt_o pulses for exactly one cycle per trigger event of the selected source, whatever en_i says. The source is input 2 when tmr_sel_i is 0 and filtered input 3 when it is 1. The trigger event follows that input's configured edge form.
- R10: Synchronous reset clears all flags, vec_o, irq_o and tmr_evt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Raw asynchronous request pins |
| mode_i | input | 8 | Two-bit trigger form per input, input n at bits 2n+1:2n |
| rate_i | input | 2 | Input 3 filter sample-rate select |
| en_i | input | 4 | Per-input enable |
| clr_i | input | 4 | Per-input pending-clear strobe |
| tmr_sel_i | input | 1 | Timer event source: 0 input 2, 1 filtered input 3 |
| pend_o | output | 4 | Pending flags |
| irq_o | output | 1 | Any flag pending |
| vec_o | output | 8 | Vector of the highest-priority pending input |
| tmr_evt_o | output | 1 | One-cycle timer count pulse |

## Verification
The bench builds the block with its defaults: four inputs, two of them level-capable, and filter dividers of 16 and 64. With these small dividers, pulses just shorter and just longer than the two-sample acceptance window can be tried at every rate within a few hundred cycles. The full priority chain 03h, 0Bh, 13h, 1Bh can be walked down one clear at a time. The cycle-exact latency checks and the same-cycle set-and-clear case depend on the fixed two-stage synchroniser.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] TRIG_RISE = 2'b00;
  localparam logic [1:0] TRIG_FALL = 2'b01;
  localparam logic [1:0] RATE_ALL  = 2'b00;
  localparam logic [1:0] RATE_MID  = 2'b01;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter
  import irq_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_i,
  input  logic       d_i,
  output logic       q_o
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam int MW = $clog2(DIV_MID);

  logic [CW-1:0] div_q;
  logic          smp_q;
  logic          tick;

  always_comb begin
    case (rate_i)
      RATE_ALL: tick = 1'b1;
      RATE_MID: tick = (div_q[MW-1:0] == '0);
      default:  tick = (div_q == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      smp_q <= 1'b0;
      q_o   <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (tick) begin
        smp_q <= d_i;
        if (d_i == smp_q) q_o <= d_i;
      end
    end
  end

  // R8: output only moves to a level that the latest sample also holds
  p_filter_two_equal_r8: assert property (@(posedge clk) disable iff (rst)
    (q_o != $past(q_o)) |-> (smp_q == q_o));
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import irq_pkg::*;
#(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       evt_o,
  output logic       pend_d_o,
  output logic       pend_o
);
  logic prev_q;
  logic rise, fall, is_level, active;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    evt_o    = 1'b0;
    is_level = 1'b0;
    active   = 1'b0;
    case (mode_i)
      TRIG_RISE: evt_o = rise;
      TRIG_FALL: evt_o = fall;
      default: begin
        if (LEVEL_OK) begin
          is_level = 1'b1;
          active   = mode_i[0] ? ~lvl_i : lvl_i;
        end else begin
          evt_o = rise | fall;
        end
      end
    endcase
    if (is_level) pend_d_o = en_i & active;
    else          pend_d_o = (evt_o & en_i) | (pend_o & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= pend_d_o;
    end
  end

  // R4: edge flag survives until a clear
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_level && pend_o && !clr_i) |=> pend_o);
  // R5: disabled level input never pending
  p_level_off_r5: assert property (@(posedge clk) disable iff (rst)
    (is_level && !en_i) |=> !pend_o);
  // R6: disabled edge input cannot raise its flag
  p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!is_level && !en_i && !pend_o) |=> !pend_o);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int             NUM_IRQ   = 4,
  parameter int             NUM_LEVEL = 2,
  parameter int             TMR_SRC   = 2,
  parameter int             VW        = 8,
  parameter logic [VW-1:0]  VEC_BASE  = 8'h03,
  parameter logic [VW-1:0]  VEC_STEP  = 8'h08,
  parameter int             DIV_MID   = 16,
  parameter int             DIV_SLOW  = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IRQ-1:0]     pin_i,
  input  logic [2*NUM_IRQ-1:0]   mode_i,
  input  logic [1:0]             rate_i,
  input  logic [NUM_IRQ-1:0]     en_i,
  input  logic [NUM_IRQ-1:0]     clr_i,
  input  logic                   tmr_sel_i,
  output logic [NUM_IRQ-1:0]     pend_o,
  output logic                   irq_o,
  output logic [VW-1:0]          vec_o,
  output logic                   tmr_evt_o
);
  localparam int FILT_IDX = NUM_IRQ - 1;

  logic [NUM_IRQ-1:0] sync_q, lvl, evt, pend_d, tmr_mask;
  logic               filt_q;
  logic [VW-1:0]      vec_d;

  irq_sync #(.W(NUM_IRQ)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(sync_q)
  );

  irq_glitch_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_filt (
    .clk(clk), .rst(rst), .rate_i(rate_i), .d_i(sync_q[FILT_IDX]), .q_o(filt_q)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ch
    if (i == FILT_IDX) begin : g_filt
      assign lvl[i] = filt_q;
    end else begin : g_raw
      assign lvl[i] = sync_q[i];
    end
    irq_trigger #(.LEVEL_OK(i < NUM_LEVEL)) u_trig (
      .clk(clk), .rst(rst), .lvl_i(lvl[i]), .mode_i(mode_i[2*i +: 2]),
      .en_i(en_i[i]), .clr_i(clr_i[i]), .evt_o(evt[i]),
      .pend_d_o(pend_d[i]), .pend_o(pend_o[i])
    );
  end

  always_comb begin
    vec_d = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend_d[i]) vec_d = VEC_BASE + VEC_STEP * VW'(i);
    end
    tmr_mask = '0;
    if (tmr_sel_i) tmr_mask[FILT_IDX] = 1'b1;
    else           tmr_mask[TMR_SRC]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o     <= '0;
      irq_o     <= 1'b0;
      tmr_evt_o <= 1'b0;
    end else begin
      vec_o     <= vec_d;
      irq_o     <= |pend_d;
      tmr_evt_o <= |(evt & tmr_mask);
    end
  end

  // R7: nothing pending means a zero vector
  p_vec_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (vec_o == '0));
  // R7: input 0 always wins
  p_vec_top_r7: assert property (@(posedge clk) disable iff (rst)
    pend_o[0] |-> (vec_o == VEC_BASE));
  // R7: any flag raises the request
  p_irq_any_r7: assert property (@(posedge clk) disable iff (rst)
    (|pend_o) |-> irq_o);
endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin = '0;
  logic [7:0] mode = '0;
  logic [1:0] rate = '0;
  logic [3:0] en = '0;
  logic [3:0] clr = '0;
  logic       tmr_sel = 1'b0;
  logic [3:0] pend;
  logic       irq;
  logic [7:0] vec;
  logic       tmr_evt;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ext_irq_unit dut (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_i(mode), .rate_i(rate),
    .en_i(en), .clr_i(clr), .tmr_sel_i(tmr_sel), .pend_o(pend),
    .irq_o(irq), .vec_o(vec), .tmr_evt_o(tmr_evt)
  );

  // {channel[1:0], mode[1:0], pin before, pin after, expected flag}
  localparam logic [6:0] TBL [14] = '{
    7'b00_00_0_1_1, 7'b00_00_1_0_0, 7'b00_01_1_0_1, 7'b00_01_0_1_0,
    7'b01_10_0_1_1, 7'b01_10_1_0_0, 7'b01_11_1_0_1, 7'b01_11_0_1_0,
    7'b10_10_0_1_1, 7'b10_10_1_0_1, 7'b10_01_0_1_0, 7'b10_11_1_0_1,
    7'b11_00_0_1_1, 7'b11_01_0_1_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; pin = '0; mode = '0; clr = '0; en = 4'hF; rate = 2'b00; tmr_sel = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    clr = m;
    wait_n(1);
    clr = '0;
  endtask

  task automatic count_tmr(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tmr_evt) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    logic [1:0] ch;
    do_reset();
    // R10 reset state
    chk("R10 pend", pend, 4'h0);
    chk("R10 vec", vec, 8'h00);
    chk("R10 irq", irq, 0);
    chk("R10 tmr", tmr_evt, 0);

    // table walk: trigger forms R2 / R3
    for (int r = 0; r < 14; r++) begin
      ch = TBL[r][6:5];
      mode = '0;
      mode[2*ch +: 2] = TBL[r][4:3];
      pin[ch] = TBL[r][2];
      wait_n(12);
      pulse_clr(4'hF);
      wait_n(3);
      pin[ch] = TBL[r][1];
      wait_n(10);
      chk(ch < 2 ? "R2 table" : "R3 table", pend[ch], TBL[r][0]);
    end

    // R1 latency and R7 vector for input 0
    do_reset();
    pin[0] = 1'b1;
    wait_n(2);
    chk("R1 not yet", pend[0], 0);
    wait_n(1);
    chk("R1 third edge", pend[0], 1);
    chk("R7 vec0", vec, 8'h03);
    chk("R7 irq", irq, 1);

    // R4 hold and clear, set wins
    wait_n(5);
    chk("R4 hold", pend[0], 1);
    pulse_clr(4'b0001);
    chk("R4 cleared", pend[0], 0);
    pin[0] = 1'b0; wait_n(4);
    pin[0] = 1'b1; wait_n(4);
    chk("R4 reset flag", pend[0], 1);
    pin[0] = 1'b0; wait_n(4);
    pin[0] = 1'b1;
    wait_n(2);
    clr[0] = 1'b1;
    wait_n(1);
    clr[0] = 1'b0;
    chk("R4 set wins over clear", pend[0], 1);
    pulse_clr(4'b0001);
    chk("R4 clear again", pend[0], 0);

    // R6 enable
    pin[0] = 1'b0; en[0] = 1'b0; wait_n(4);
    pin[0] = 1'b1; wait_n(5);
    chk("R6 disabled edge ignored", pend[0], 0);
    en[0] = 1'b1; pin[0] = 1'b0; wait_n(4);
    pin[0] = 1'b1; wait_n(5);
    chk("R6 enabled sets", pend[0], 1);
    en[0] = 1'b0; wait_n(3);
    chk("R6 kept while disabled", pend[0], 1);
    pulse_clr(4'b0001);
    chk("R6 clear while disabled", pend[0], 0);
    en[0] = 1'b1;

    // R5 level mode on input 1
    mode[3:2] = 2'b10;
    pin[1] = 1'b1; wait_n(5);
    chk("R5 high level", pend[1], 1);
    chk("R7 vec1", vec, 8'h0B);
    pulse_clr(4'b0010);
    chk("R5 clear no effect", pend[1], 1);
    en[1] = 1'b0; wait_n(1);
    chk("R5 disabled", pend[1], 0);
    en[1] = 1'b1; wait_n(1);
    chk("R5 re-enabled", pend[1], 1);
    pin[1] = 1'b0; wait_n(5);
    chk("R5 level gone", pend[1], 0);

    // R7 priority chain
    do_reset();
    pin = 4'b1110; wait_n(8);
    chk("R7 pend set", pend, 4'b1110);
    chk("R7 vec 1 wins", vec, 8'h0B);
    pulse_clr(4'b0010);
    chk("R7 others stay", pend, 4'b1100);
    chk("R7 vec2", vec, 8'h13);
    pin[0] = 1'b1; wait_n(4);
    chk("R7 vec0 wins", vec, 8'h03);
    pulse_clr(4'b0001);
    chk("R7 back to 2", vec, 8'h13);
    pulse_clr(4'b0100);
    chk("R7 vec3", vec, 8'h1B);
    pulse_clr(4'b1000);
    chk("R7 idle vec", vec, 8'h00);
    chk("R7 idle irq", irq, 0);

    // R8 filter rates on input 3, rising edge
    do_reset();
    pin[3] = 1'b1; wait_n(1); pin[3] = 1'b0; wait_n(10);
    chk("R8 rate1 1-cycle rejected", pend[3], 0);
    pin[3] = 1'b1; wait_n(2); pin[3] = 1'b0; wait_n(10);
    chk("R8 rate1 2-cycle accepted", pend[3], 1);
    pulse_clr(4'b1000);
    rate = 2'b01; wait_n(20);
    pin[3] = 1'b1; wait_n(10); pin[3] = 1'b0; wait_n(60);
    chk("R8 rate16 short rejected", pend[3], 0);
    pin[3] = 1'b1; wait_n(40); pin[3] = 1'b0; wait_n(60);
    chk("R8 rate16 long accepted", pend[3], 1);
    pulse_clr(4'b1000);
    rate = 2'b11; wait_n(20);
    pin[3] = 1'b1; wait_n(40); pin[3] = 1'b0; wait_n(200);
    chk("R8 rate64 short rejected", pend[3], 0);
    rate = 2'b10;
    pin[3] = 1'b1; wait_n(140); pin[3] = 1'b0; wait_n(200);
    chk("R8 rate64 long accepted", pend[3], 1);

    // R9 timer event
    do_reset();
    en = '0;
    pin[2] = 1'b1; count_tmr(8, c);
    chk("R9 input2 rise pulse", c, 1);
    chk("R9 flag untouched when disabled", pend[2], 0);
    mode[5:4] = 2'b10;
    pin[2] = 1'b0; count_tmr(8, c);
    chk("R9 input2 both-edge fall", c, 1);
    tmr_sel = 1'b1;
    mode[7:6] = 2'b01;
    pin[3] = 1'b1; count_tmr(10, c);
    chk("R9 input3 rise ignored in fall mode", c, 0);
    pin[3] = 1'b0; count_tmr(10, c);
    chk("R9 input3 fall pulse", c, 1);
    mode[7:6] = 2'b00;
    pin[3] = 1'b1; wait_n(1); pin[3] = 1'b0; count_tmr(10, c);
    chk("R9 glitch gives no pulse", c, 0);
    pin[2] = 1'b1; count_tmr(8, c);
    chk("R9 input2 unselected", c, 0);

    // R10 reset mid-run
    en = 4'hF; tmr_sel = 1'b0; mode = '0;
    pin[0] = 1'b0; wait_n(4); pin[0] = 1'b1; wait_n(4);
    chk("R10 flag before reset", pend[0], 1);
    rst = 1'b1; wait_n(1);
    chk("R10 reset clears pend", pend, 4'h0);
    chk("R10 reset clears vec", vec, 8'h00);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule